// File: doc/BRIEF.md
# Prescaled Compare and Capture Timer

This block is a free-running timer that counts prescaled ticks. A down-counting prescaler produces one tick every `divisor + 1` clocks, and each tick advances a 32-bit timer by one. The timer wraps from all ones back to zero. Software can load a new divisor at once, which restarts the prescale period. It can instead park the new divisor until the running period finishes.

A compare register is tested against the timer on every clock. The test takes the timer minus the compare value modulo 2^32, and the timer counts as having reached the compare value when the top bit of that difference is clear. This keeps the result correct when the count wraps past zero. The interrupt output is high while the compare is reached and the active-low enable input is low.

A capture unit watches an event input. On the first clock that the input level equals the programmed polarity, it stores the low 16 timer bits and sets a sticky event flag.

Top module: `pscl_timer`

## Requirements
- R1: After reset the timer reads 0, the capture register reads 0, the event flag is 0, the compare register holds 0x8000_0000 (so `cmp_hit` is 0), and the divisor is 0, which gives one tick per clock.
- R2: The timer increments by one on every prescaler tick, one tick every `divisor + 1` clocks, and wraps from 0xFFFF_FFFF to 0.
- R3: A divisor write with `psc_defer` = 0 takes effect at once. The prescale count reloads with the new value on that clock edge, and the first tick comes `divisor + 1` clocks after the write edge.
- R4: A divisor write with `psc_defer` = 1 does not disturb the running period. The old period completes, and the new divisor governs every period after that.
- R5: A timer write loads `tmr_wdata` on that edge and overrides any increment due on the same edge.
- R6: `cmp_hit` is 1 exactly when bit 31 of (timer − compare) mod 2^32 is 0. It is evaluated every clock, including after the timer wraps past zero.
- R7: `irq` equals `cmp_hit` while `irq_en_n` is 0, and `irq` is 0 while `irq_en_n` is 1.
- R8: A compare write is reflected in `cmp_hit` and `irq` one clock after the write edge.
- R9: On the first clock edge at which `evt_in` equals `evt_pol`, the capture register takes timer bits 15..0 as they stood before that edge, and the event flag sets.
- R10: While the level keeps matching, no further capture occurs. A level that does not match the polarity changes neither the capture register nor the flag.
- R11: The event flag stays set until `evt_clr` is pulsed. If a capture and a clear fall on the same edge, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_wr | input | 1 | Divisor write strobe |
| psc_defer | input | 1 | 1: apply the divisor at the end of the running period; 0: apply it at once |
| psc_wdata | input | 8 | Divisor value; the period is value + 1 clocks |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 32 | Timer write value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 32 | Compare write value |
| irq_en_n | input | 1 | Interrupt enable, active low |
| evt_pol | input | 1 | Event level that triggers a capture |
| evt_in | input | 1 | Event input level |
| evt_clr | input | 1 | Clears the event flag |
| tmr_q | output | 32 | Current timer value |
| cmp_hit | output | 1 | Timer is at or past the compare value |
| irq | output | 1 | Timer interrupt |
| evt_flag | output | 1 | Sticky capture flag |
| cap_q | output | 16 | Captured low timer bits |

## Verification
A wrong prescale count or a misapplied divisor appears on `tmr_q` within one prescale period, as an increment that comes a clock early or late. A broken modulo compare is visible only near the wrap or at equality. The directed cases therefore place the compare value one count ahead of the timer and step the timer across zero while checking `cmp_hit` on every clock. Capture faults show in `cap_q` on the edge after the level first matches, or as a changed value while the level is held, so each capture case is checked on the edge itself and again several clocks later.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int TMR_W_DEF = 32;
  localparam int CAP_W_DEF = 16;
  localparam int PSC_W_DEF = 8;
endpackage

// File: rtl/pscl_prescaler.sv
module pscl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             defer,
  input  logic [PSC_W-1:0] wdata,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt, div_act, div_pend, next_div;
  logic             pend_v, wr_now, wr_late;

  assign tick     = (pcnt == '0);
  assign wr_now   = wr && !defer;
  assign wr_late  = wr && defer;
  assign next_div = wr_late ? wdata : (pend_v ? div_pend : div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      div_act  <= '0;
      div_pend <= '0;
      pend_v   <= 1'b0;
    end else if (wr_now) begin
      pcnt    <= wdata;
      div_act <= wdata;
      pend_v  <= 1'b0;
    end else if (tick) begin
      pcnt    <= next_div;
      div_act <= next_div;
      pend_v  <= 1'b0;
    end else begin
      pcnt <= pcnt - 1'b1;
      if (wr_late) begin
        div_pend <= wdata;
        pend_v   <= 1'b1;
      end
    end
  end

  // R3: immediate write restarts the period with the new value
  a_r3_imm_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> pcnt == $past(wdata));
  // R4: deferred write leaves the running period untouched
  a_r4_defer_keeps_period: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_late && !tick) |=> pcnt == $past(pcnt) - 1'b1);
  // R2: after a tick without a write, the count reloads from a stored divisor
  a_r2_reload_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr) |=> (pcnt == div_act));
endmodule

// File: rtl/pscl_counter.sv
module pscl_counter #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [TMR_W-1:0] wdata,
  output logic [TMR_W-1:0] tmr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr <= '0;
    else if (wr)   tmr <= wdata;
    else if (tick) tmr <= tmr + 1'b1;
  end

  // R2: one count per tick, wrapping naturally
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr) |=> tmr == $past(tmr) + 1'b1);
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(tmr));
  // R5: write beats increment
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> tmr == $past(wdata));
endmodule

// File: rtl/pscl_compare.sv
module pscl_compare #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [TMR_W-1:0] wdata,
  input  logic [TMR_W-1:0] tmr,
  input  logic             irq_en_n,
  output logic             hit,
  output logic             irq
);
  localparam logic [TMR_W-1:0] CMP_RST = {1'b1, {(TMR_W-1){1'b0}}};

  logic [TMR_W-1:0] cmp;

  function automatic logic at_or_past(input logic [TMR_W-1:0] t,
                                      input logic [TMR_W-1:0] c);
    logic [TMR_W-1:0] diff;
    diff = t - c;
    return ~diff[TMR_W-1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmp <= CMP_RST;
    else if (wr) cmp <= wdata;
  end

  assign hit = at_or_past(tmr, cmp);
  assign irq = hit && !irq_en_n;

  // R6: equality always counts as reached
  a_r6_equal_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr == cmp) |-> hit);
  // R7: disabled interrupt never asserts
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_n |-> !irq);
  // R8: compare write lands on the next clock
  a_r8_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cmp == $past(wdata));
endmodule

// File: rtl/pscl_capture.sv
module pscl_capture #(
  parameter int TMR_W = 32,
  parameter int CAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pol,
  input  logic             evt,
  input  logic             clr,
  input  logic [TMR_W-1:0] tmr,
  output logic             flag,
  output logic [CAP_W-1:0] cap
);
  logic match, match_d, fire;

  assign match = (evt == pol);
  assign fire  = match && !match_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_d <= 1'b0;
      flag    <= 1'b0;
      cap     <= '0;
    end else begin
      match_d <= match;
      if (fire) begin
        cap  <= tmr[CAP_W-1:0];
        flag <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  // R9: capture takes the pre-edge timer bits and sets the flag
  a_r9_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cap == $past(tmr[CAP_W-1:0])) && flag);
  // R10: held or non-matching level leaves the register alone
  a_r10_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cap));
  // R11: flag is sticky without a clear
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_pkg::*;
#(
  parameter int TMR_W = TMR_W_DEF,
  parameter int CAP_W = CAP_W_DEF,
  parameter int PSC_W = PSC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psc_wr,
  input  logic             psc_defer,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             cmp_wr,
  input  logic [TMR_W-1:0] cmp_wdata,
  input  logic             irq_en_n,
  input  logic             evt_pol,
  input  logic             evt_in,
  input  logic             evt_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             cmp_hit,
  output logic             irq,
  output logic             evt_flag,
  output logic [CAP_W-1:0] cap_q
);
  logic tick;

  pscl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .wr(psc_wr), .defer(psc_defer),
    .wdata(psc_wdata), .tick(tick));

  pscl_counter #(.TMR_W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(tmr_wr),
    .wdata(tmr_wdata), .tmr(tmr_q));

  pscl_compare #(.TMR_W(TMR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(cmp_wdata),
    .tmr(tmr_q), .irq_en_n(irq_en_n), .hit(cmp_hit), .irq(irq));

  pscl_capture #(.TMR_W(TMR_W), .CAP_W(CAP_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pol(evt_pol), .evt(evt_in), .clr(evt_clr),
    .tmr(tmr_q), .flag(evt_flag), .cap(cap_q));
endmodule

// File: tb/pscl_timer_bench.sv
module pscl_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psc_wr = 0, psc_defer = 0;
  logic [7:0]  psc_wdata = 0;
  logic        tmr_wr = 0, cmp_wr = 0;
  logic [31:0] tmr_wdata = 0, cmp_wdata = 0;
  logic        irq_en_n = 1, evt_pol = 1, evt_in = 0, evt_clr = 0;
  logic [31:0] tmr_q;
  logic        cmp_hit, irq, evt_flag;
  logic [15:0] cap_q;

  int nvec = 0, nfail = 0;
  logic [15:0] cap_exp;

  always #2 clk = ~clk;

  pscl_timer u_pscl_timer (
    .clk(clk), .rst_n(rst_n), .psc_wr(psc_wr), .psc_defer(psc_defer),
    .psc_wdata(psc_wdata), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .irq_en_n(irq_en_n),
    .evt_pol(evt_pol), .evt_in(evt_in), .evt_clr(evt_clr), .tmr_q(tmr_q),
    .cmp_hit(cmp_hit), .irq(irq), .evt_flag(evt_flag), .cap_q(cap_q));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_tmr_cmp(input logic [31:0] t, input logic [31:0] c);
    tmr_wr = 1; tmr_wdata = t; cmp_wr = 1; cmp_wdata = c;
    step(1);
    tmr_wr = 0; cmp_wr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 timer", tmr_q, 0);
    chk("R1 cap", {16'h0, cap_q}, 0);
    chk("R1 flag", {31'h0, evt_flag}, 0);
    chk("R1 hit", {31'h0, cmp_hit}, 0);
    rst_n = 1;
    step(1);
    chk("R1 tick every clock", tmr_q, 1);
    step(1);
    chk("R2 tick every clock", tmr_q, 2);
  endtask

  task automatic t_compare();
    irq_en_n = 0;
    wr_tmr_cmp(32'd10, 32'd12);
    chk("R6 below", {30'h0, cmp_hit, irq}, 0);
    step(1);
    chk("R6 one below", {30'h0, cmp_hit, irq}, 0);
    step(1);
    chk("R6 equal", {30'h0, cmp_hit, irq}, 3);
    step(1);
    chk("R6 past", {30'h0, cmp_hit, irq}, 3);
    irq_en_n = 1;
    #1;
    chk("R7 masked", {30'h0, cmp_hit, irq}, 2);
    irq_en_n = 0;
  endtask

  task automatic t_wrap();
    wr_tmr_cmp(32'hFFFF_FFFD, 32'hFFFF_FFFE);
    chk("R6 wrap below", {31'h0, cmp_hit}, 0);
    step(1);
    chk("R6 wrap equal", {31'h0, irq}, 1);
    step(1);
    chk("R2 wrap top", tmr_q, 32'hFFFF_FFFF);
    step(1);
    chk("R2 wrap zero", tmr_q, 0);
    chk("R6 past across wrap", {31'h0, cmp_hit}, 1);
  endtask

  task automatic t_cmp_write();
    cmp_wr = 1; cmp_wdata = 32'h100;
    step(1);
    cmp_wr = 0;
    chk("R8 new compare next clock", {30'h0, cmp_hit, irq}, 0);
    cmp_wr = 1; cmp_wdata = 32'h0;
    step(1);
    cmp_wr = 0;
    chk("R8 compare lowered", {30'h0, cmp_hit, irq}, 3);
  endtask

  task automatic t_tmr_priority();
    tmr_wr = 1; tmr_wdata = 32'h55;
    step(1);
    tmr_wr = 0;
    chk("R5 write over tick", tmr_q, 32'h55);
  endtask

  task automatic t_capture_high();
    evt_pol = 1; evt_in = 0;
    tmr_wr = 1; tmr_wdata = 32'h0001_2345;
    step(1);
    tmr_wr = 0;
    evt_in = 1;
    step(1);
    chk("R9 capture value", {16'h0, cap_q}, 32'h2345);
    chk("R9 flag set", {31'h0, evt_flag}, 1);
    step(3);
    chk("R10 held level no recapture", {16'h0, cap_q}, 32'h2345);
    evt_in = 0;
    step(1);
    evt_in = 1;
    step(1);
    chk("R9 second capture", {16'h0, cap_q}, 32'h234A);
    evt_clr = 1;
    step(1);
    evt_clr = 0;
    chk("R11 cleared", {31'h0, evt_flag}, 0);
    step(2);
    chk("R11 stays clear", {31'h0, evt_flag}, 0);
    evt_in = 0;
    step(1);
    evt_in = 1; evt_clr = 1;
    step(1);
    evt_clr = 0;
    chk("R11 capture beats clear", {31'h0, evt_flag}, 1);
  endtask

  task automatic t_capture_low();
    evt_clr = 1;
    step(1);
    evt_clr = 0;
    cap_exp = cap_q;
    evt_pol = 0; evt_in = 1;
    step(3);
    chk("R10 mismatch ignored cap", {16'h0, cap_q}, {16'h0, cap_exp});
    chk("R10 mismatch ignored flag", {31'h0, evt_flag}, 0);
    tmr_wr = 1; tmr_wdata = 32'hABCD_0777;
    step(1);
    tmr_wr = 0;
    evt_in = 0;
    step(1);
    chk("R9 low polarity capture", {16'h0, cap_q}, 32'h0777);
    chk("R9 low polarity flag", {31'h0, evt_flag}, 1);
    evt_pol = 1;
  endtask

  task automatic t_psc_imm();
    psc_wr = 1; psc_defer = 0; psc_wdata = 8'd3;
    tmr_wr = 1; tmr_wdata = 0;
    step(1);
    psc_wr = 0; tmr_wr = 0;
    step(3);
    chk("R2 no tick before period", tmr_q, 0);
    step(1);
    chk("R2 tick after 4 clocks", tmr_q, 1);
    step(4);
    chk("R2 second period", tmr_q, 2);
    psc_wr = 1; psc_wdata = 8'd3; tmr_wr = 1; tmr_wdata = 0;
    step(1);
    psc_wr = 0; tmr_wr = 0;
    step(1);
    psc_wr = 1; psc_defer = 0; psc_wdata = 8'd0;
    step(1);
    psc_wr = 0;
    chk("R3 write edge", tmr_q, 0);
    step(1);
    chk("R3 immediate tick", tmr_q, 1);
    step(1);
    chk("R3 new rate", tmr_q, 2);
  endtask

  task automatic t_psc_defer();
    psc_wr = 1; psc_defer = 0; psc_wdata = 8'd3; tmr_wr = 1; tmr_wdata = 0;
    step(1);
    psc_wr = 0; tmr_wr = 0;
    step(1);
    psc_wr = 1; psc_defer = 1; psc_wdata = 8'd0;
    step(1);
    psc_wr = 0; psc_defer = 0;
    step(1);
    chk("R4 old period runs on", tmr_q, 0);
    step(1);
    chk("R4 old period ends", tmr_q, 1);
    step(1);
    chk("R4 new divisor applies", tmr_q, 2);
  endtask

  initial begin
    t_reset();
    t_compare();
    t_wrap();
    t_cmp_write();
    t_tmr_priority();
    t_capture_high();
    t_capture_low();
    t_psc_imm();
    t_psc_defer();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule